// File: doc/BRIEF.md
# Serial EEPROM word write sequencer

This block stores one 16-bit word into a three-wire serial EEPROM with a clocked serial command interface. A one-cycle start strobe, given while the block is idle, captures a word address and a data word. The block then drives the chip-select, serial-clock and data-in pins through a fixed sequence. First comes an erase/write enable command. Chip select is then pulsed low. Next comes the write command, which carries the address and the byte-swapped data. After a second chip-select pulse, the block polls the device's data-out pin for the ready level.

All pin timing comes from one step period of `STEP_CYC` clock cycles; the default of 50 cycles gives 1 µs at a 50 MHz clock. Each serial bit takes three steps. The ready poll samples data-out once per check. After each failed check it waits `POLL_CYC` cycles, which by default gives 10 ms at 50 MHz. After `POLL_TRIES` failed checks it gives up. In both outcomes the block finishes with chip select low and a one-cycle `done_o` pulse, and `timeout_o` tells whether the device never became ready.

The controller is a state machine with these states: `ST_IDLE`, `ST_EN_SEL`, `ST_EN_SHIFT`, `ST_EN_DESEL`, `ST_WR_SEL`, `ST_WR_SHIFT`, `ST_PG_DESEL`, `ST_PG_SEL`, `ST_POLL_CHK`, `ST_POLL_WAIT` and `ST_FINISH`. Its transitions are:
- IDLE goes to EN_SEL on start.
- EN_SEL goes to EN_SHIFT at the end of a step.
- EN_SHIFT goes to EN_DESEL after the last bit.
- EN_DESEL goes to WR_SEL at the end of a step.
- WR_SEL goes to WR_SHIFT at the end of a step.
- WR_SHIFT goes to PG_DESEL after the last bit.
- PG_DESEL goes to PG_SEL at the end of a step.
- PG_SEL goes to POLL_CHK at the end of a step.
- POLL_CHK goes to FINISH when data-out is 1, and to POLL_WAIT otherwise.
- POLL_WAIT goes to FINISH at the end of the interval once all checks are used up, and back to POLL_CHK otherwise.
- FINISH always goes to IDLE.

Top module: `eewr_seq`

## Requirements
- R1: While reset is asserted and after it, with no start given, `ee_cs_o`, `ee_sk_o`, `ee_di_o`, `done_o` and `timeout_o` are all 0.
- R2: A start sampled in idle is followed by one step with chip select high and clock low. The enable frame follows: bits 1, 0, 0, then `ADDR_W` ones, most significant bit first.
- R3: After the enable frame, chip select is low for one step and then high for one step before the write frame starts.
- R4: The write frame is bits 1, 0, 1, then the address MSB first, then the data with its bytes exchanged, MSB first. The data goes out as bit 7 down to bit 0, then bit 15 down to bit 8.
- R5: Each frame bit lasts three steps of `STEP_CYC` cycles. In the first step, data-in holds the bit and the clock is low. In the second, the clock is high. In the third, the clock is low again with data-in unchanged. The clock is only ever high while chip select is high.
- R6: After the write frame, chip select is low for one step and then high for one step. Data-in and the clock stay low during both steps.
- R7: During polling, chip select stays high. Data-out is sampled in a one-cycle check, and failed checks are separated by `POLL_CYC`-cycle waits. A check that sees 1 leads to the finish cycle with `timeout_o` = 0.
- R8: When `POLL_TRIES` checks have all seen 0, the finish cycle follows the wait after the last check, with `timeout_o` = 1.
- R9: The finish cycle is a single cycle with `done_o` = 1 and chip select low. The block is idle in the next cycle.
- R10: A start given while the block is busy, including in the finish cycle, is ignored and does not change the pin sequence. A start that is held high is accepted again in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| addr_i | input | ADDR_W | Word address, captured at start |
| data_i | input | 16 | Data word, captured at start |
| ee_do_i | input | 1 | EEPROM data-out (ready level during polling) |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | EEPROM data-in |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Valid with done_o: 1 when the device never reported ready |

## Verification
The assertions check the following on every cycle:
- the serial clock only pulses inside a chip-select window;
- data-in never changes on a clock edge;
- done lasts one cycle, with chip select low, and comes right after a cycle with chip select high;
- timeout never appears without done.

Only the bench's scenarios show that the frames contain the right bits in the right order, including the byte swap, and that each bit gets exactly three steps. The same holds for the count of checks and waits before ready or timeout, and for a start during a busy sequence being ignored. The bench compares the pins with a behavioural model on every cycle.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

    localparam int OP_W   = 3;
    localparam int WORD_W = 16;

    // start bit plus two-bit opcode
    localparam logic [OP_W-1:0] EN_OP = 3'b100;
    localparam logic [OP_W-1:0] WR_OP = 3'b101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EN_SEL,
        ST_EN_SHIFT,
        ST_EN_DESEL,
        ST_WR_SEL,
        ST_WR_SHIFT,
        ST_PG_DESEL,
        ST_PG_SEL,
        ST_POLL_CHK,
        ST_POLL_WAIT,
        ST_FINISH
    } wr_state_e;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[WORD_W/2-1:0], w[WORD_W-1:WORD_W/2]};
    endfunction

endpackage

// File: rtl/eewr_step_timer.sv
module eewr_step_timer #(
    parameter int STEP_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic step_end_o
);
    generate
        if (STEP_CYC <= 1) begin : g_single
            assign step_end_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(STEP_CYC);
            localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run_i || cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign step_end_o = run_i && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/eewr_shifter.sv
module eewr_shifter
    import eewr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic              load_wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              adv_i,
    output logic              di_o,
    output logic              sk_o,
    output logic              frame_end_o
);
    localparam int FRAME_W = OP_W + ADDR_W + WORD_W;
    localparam int LW      = $clog2(FRAME_W + 1);
    localparam logic [1:0] PH_SETUP = 2'd0;
    localparam logic [1:0] PH_HIGH  = 2'd1;
    localparam logic [1:0] PH_HOLD  = 2'd2;

    logic [FRAME_W-1:0] sreg_q;
    logic [LW-1:0]      left_q;
    logic [1:0]         phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q  <= '0;
            left_q  <= '0;
            phase_q <= PH_SETUP;
        end else if (load_en_i) begin
            sreg_q  <= {EN_OP, {ADDR_W{1'b1}}, {WORD_W{1'b0}}};
            left_q  <= LW'(OP_W + ADDR_W);
            phase_q <= PH_SETUP;
        end else if (load_wr_i) begin
            sreg_q  <= {WR_OP, addr_i, swap_bytes(data_i)};
            left_q  <= LW'(FRAME_W);
            phase_q <= PH_SETUP;
        end else if (adv_i) begin
            if (phase_q == PH_HOLD) begin
                phase_q <= PH_SETUP;
                sreg_q  <= {sreg_q[FRAME_W-2:0], 1'b0};
                left_q  <= left_q - 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign di_o        = sreg_q[FRAME_W-1];
    assign sk_o        = (phase_q == PH_HIGH);
    assign frame_end_o = adv_i && (phase_q == PH_HOLD) && (left_q == LW'(1));
endmodule

// File: rtl/eewr_poll.sv
module eewr_poll #(
    parameter int POLL_CYC   = 500000,
    parameter int POLL_TRIES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic fail_i,
    output logic wait_end_o,
    output logic spent_o
);
    localparam int TW = $clog2(POLL_TRIES + 1);
    logic [TW-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (clr_i) begin
            tries_q <= '0;
        end else if (fail_i) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign spent_o = (tries_q == TW'(POLL_TRIES));

    generate
        if (POLL_CYC <= 1) begin : g_single
            assign wait_end_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(POLL_CYC);
            localparam logic [CW-1:0] LAST = CW'(POLL_CYC - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run_i || cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign wait_end_o = run_i && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/eewr_seq.sv
module eewr_seq
    import eewr_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int STEP_CYC   = 50,
    parameter int POLL_CYC   = 500000,
    parameter int POLL_TRIES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              ee_do_i,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    output logic              done_o,
    output logic              timeout_o
);
    wr_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic              tout_q;

    logic step_run, step_end;
    logic sh_di, sh_sk, sh_end, in_shift;
    logic wait_end, spent, chk_fail;

    assign step_run = (state_q == ST_EN_SEL)   || (state_q == ST_EN_SHIFT) ||
                      (state_q == ST_EN_DESEL) || (state_q == ST_WR_SEL)   ||
                      (state_q == ST_WR_SHIFT) || (state_q == ST_PG_DESEL) ||
                      (state_q == ST_PG_SEL);
    assign in_shift = (state_q == ST_EN_SHIFT) || (state_q == ST_WR_SHIFT);
    assign chk_fail = (state_q == ST_POLL_CHK) && !ee_do_i;

    eewr_step_timer #(.STEP_CYC(STEP_CYC)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (step_run),
        .step_end_o (step_end)
    );

    eewr_shifter #(.ADDR_W(ADDR_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (state_q == ST_EN_SEL),
        .load_wr_i   (state_q == ST_WR_SEL),
        .addr_i      (addr_q),
        .data_i      (data_q),
        .adv_i       (in_shift && step_end),
        .di_o        (sh_di),
        .sk_o        (sh_sk),
        .frame_end_o (sh_end)
    );

    eewr_poll #(.POLL_CYC(POLL_CYC), .POLL_TRIES(POLL_TRIES)) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (state_q == ST_IDLE),
        .run_i      (state_q == ST_POLL_WAIT),
        .fail_i     (chk_fail),
        .wait_end_o (wait_end),
        .spent_o    (spent)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request and outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            tout_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                addr_q <= addr_i;
                data_q <= data_i;
                tout_q <= 1'b0;
            end
            if (state_q == ST_POLL_WAIT && wait_end && spent) begin
                tout_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i)  state_d = ST_EN_SEL;
            ST_EN_SEL:    if (step_end) state_d = ST_EN_SHIFT;
            ST_EN_SHIFT:  if (sh_end)   state_d = ST_EN_DESEL;
            ST_EN_DESEL:  if (step_end) state_d = ST_WR_SEL;
            ST_WR_SEL:    if (step_end) state_d = ST_WR_SHIFT;
            ST_WR_SHIFT:  if (sh_end)   state_d = ST_PG_DESEL;
            ST_PG_DESEL:  if (step_end) state_d = ST_PG_SEL;
            ST_PG_SEL:    if (step_end) state_d = ST_POLL_CHK;
            ST_POLL_CHK:  state_d = ee_do_i ? ST_FINISH : ST_POLL_WAIT;
            ST_POLL_WAIT: if (wait_end) state_d = spent ? ST_FINISH : ST_POLL_CHK;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ee_cs_o   = 1'b0;
        ee_sk_o   = 1'b0;
        ee_di_o   = 1'b0;
        done_o    = 1'b0;
        timeout_o = 1'b0;
        unique case (state_q)
            ST_EN_SHIFT, ST_WR_SHIFT: begin
                ee_cs_o = 1'b1;
                ee_sk_o = sh_sk;
                ee_di_o = sh_di;
            end
            ST_EN_SEL, ST_WR_SEL, ST_PG_SEL, ST_POLL_CHK, ST_POLL_WAIT: begin
                ee_cs_o = 1'b1;
            end
            ST_FINISH: begin
                done_o    = 1'b1;
                timeout_o = tout_q;
            end
            default: begin
                ee_cs_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eewr_seq_chk.sv
module eewr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di,
    input logic done,
    input logic timeout
);
    p_sk_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    p_di_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> $stable(ee_di));

    p_di_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> $stable(ee_di));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ee_cs);

    p_done_after_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ee_cs));

    p_tout_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
endmodule

bind eewr_seq eewr_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ee_cs   (ee_cs_o),
    .ee_sk   (ee_sk_o),
    .ee_di   (ee_di_o),
    .done    (done_o),
    .timeout (timeout_o)
);

// File: tb/tb_eewr_seq.sv
module tb_eewr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int SC = 2;
    localparam int PC = 20;
    localparam int PT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   data = '0;
    logic          ee_do = 1'b0;
    logic          ee_cs, ee_sk, ee_di, done, tout;

    always #(CLK_PERIOD/2) clk = ~clk;

    eewr_seq #(.ADDR_W(AW), .STEP_CYC(SC), .POLL_CYC(PC), .POLL_TRIES(PT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .addr_i    (addr),
        .data_i    (data),
        .ee_do_i   (ee_do),
        .ee_cs_o   (ee_cs),
        .ee_sk_o   (ee_sk),
        .ee_di_o   (ee_di),
        .done_o    (done),
        .timeout_o (tout)
    );

    int    checks = 0;
    int    errors = 0;
    bit    model_on = 1'b0;
    bit    finished = 1'b0;
    logic  e_cs = 0, e_sk = 0, e_di = 0, e_done = 0, e_tout = 0;
    string e_req = "R1";
    int    polls = 0;
    int    n_done_seen = 0, n_done_exp = 0;
    int    n_tout_seen = 0, n_tout_exp = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if ({ee_cs, ee_sk, ee_di, done, tout} !== {e_cs, e_sk, e_di, e_done, e_tout}) begin
                errors++;
                $display("FAIL %s actual cs/sk/di/done/tout=%b%b%b%b%b expected=%b%b%b%b%b",
                         e_req, ee_cs, ee_sk, ee_di, done, tout,
                         e_cs, e_sk, e_di, e_done, e_tout);
            end
            if (done) n_done_seen++;
            if (tout) n_tout_seen++;
        end
    end

    task automatic hold(logic cs, logic sk, logic di, int n, string req);
        e_cs = cs; e_sk = sk; e_di = di; e_done = 0; e_tout = 0; e_req = req;
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic send_bit(logic b, string req);
        hold(1'b1, 1'b0, b, SC, req);
        hold(1'b1, 1'b1, b, SC, "R5");
        hold(1'b1, 1'b0, b, SC, "R5");
    endtask

    // behavioural reference model
    initial begin : model
        logic [AW-1:0] a;
        logic [15:0]   sw;
        int            tries;
        logic          ready;
        wait (rst_n === 1'b1);
        forever begin
            hold(1'b0, 1'b0, 1'b0, 1, "R10");
            if (start) begin
                a  = addr;
                sw = {data[7:0], data[15:8]};
                hold(1'b1, 1'b0, 1'b0, SC, "R2");
                send_bit(1'b1, "R2");
                send_bit(1'b0, "R2");
                send_bit(1'b0, "R2");
                repeat (AW) send_bit(1'b1, "R2");
                hold(1'b0, 1'b0, 1'b0, SC, "R3");
                hold(1'b1, 1'b0, 1'b0, SC, "R3");
                send_bit(1'b1, "R4");
                send_bit(1'b0, "R4");
                send_bit(1'b1, "R4");
                for (int i = AW-1; i >= 0; i--) send_bit(a[i], "R4");
                for (int i = 15; i >= 0; i--) send_bit(sw[i], "R4");
                hold(1'b0, 1'b0, 1'b0, SC, "R6");
                hold(1'b1, 1'b0, 1'b0, SC, "R6");
                tries = 0;
                ready = 1'b0;
                forever begin
                    hold(1'b1, 1'b0, 1'b0, 1, "R7");
                    ready = ee_do;
                    polls++;
                    if (ready) break;
                    hold(1'b1, 1'b0, 1'b0, PC, "R7");
                    tries++;
                    if (tries == PT) break;
                end
                e_cs = 0; e_sk = 0; e_di = 0; e_done = 1; e_tout = !ready;
                e_req = ready ? "R9" : "R8";
                n_done_exp++;
                if (!ready) n_tout_exp++;
                @(posedge clk); #1;
                e_done = 0; e_tout = 0;
            end
        end
    end

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start(logic [AW-1:0] a, logic [15:0] d);
        addr = a; data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : stim
        int base;
        repeat (3) @(negedge clk);
        check("R1 cs in reset", int'(ee_cs), 0);
        check("R1 sk in reset", int'(ee_sk), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 di idle", int'(ee_di), 0);
        check("R1 timeout idle", int'(tout), 0);

        // ready on the third check (R7)
        ee_do = 1'b0;
        base = polls;
        pulse_start(6'h2A, 16'h1234);
        wait (polls == base + 2);
        @(negedge clk);
        ee_do = 1'b1;
        wait_done();
        ee_do = 1'b0;
        check("R7 checks before ready", polls - base, 3);
        repeat (3) @(negedge clk);

        // data-out already high: ready at first check (R7)
        ee_do = 1'b1;
        base = polls;
        pulse_start(6'h3F, 16'h00A5);
        wait_done();
        check("R7 single check", polls - base, 1);
        ee_do = 1'b0;
        repeat (2) @(negedge clk);

        // never ready: timeout, with starts given while busy (R8, R10)
        base = polls;
        pulse_start(6'h00, 16'hFFFF);
        repeat (40) @(negedge clk);
        pulse_start(6'h15, 16'h5A5A);
        repeat (300) @(negedge clk);
        pulse_start(6'h15, 16'h5A5A);
        wait_done();
        check("R8 check count", polls - base, PT);
        check("R8 timeout count", n_tout_seen, 1);

        // start held high through finish: back-to-back (R10)
        ee_do = 1'b1;
        addr = 6'h01; data = 16'hC381; start = 1'b1;
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        ee_do = 1'b0;
        repeat (5) @(negedge clk);

        check("R10 accepted count", n_done_exp, 5);
        check("R9 done pulses", n_done_seen, n_done_exp);
        check("R8 timeouts", n_tout_seen, n_tout_exp);
        summary();
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end
endmodule